// File: doc/BRIEF.md
# Single-Cycle Register-to-Register Datapath

This block is the execution half of a small load/store processor. It holds eight 16-bit general registers, a function unit with a five-bit operation code and four status flags, and a small word-addressed data memory. Each clock cycle it is steered by a flat control word: a register-write enable and its destination, two read selects, a select that replaces the second operand with an external constant, the operation code, a write-back select (function result or memory word) and a memory-write enable. Fetch, decode and program sequencing sit outside the block and deliver that control word.

Every path is combinational from the register outputs to the write-back bus and the flags. Register and memory updates happen together on the rising clock edge. The memory is addressed only by the value on the first read port. The data it stores is whatever the operand-B selector passes, so a register value or an external constant can both be written to memory. Memory words reach the function unit only after they have been loaded into a register.

Top module: `regrtx_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to zero; both read ports then return 0x0000 for every select.
- R2: When `wr_en` is 1, the register chosen by `dst_sel` takes the value of `wb_data` at the rising edge. `a_data` shows the register chosen by `srca_sel` without a clock, and `b_data` shows the register chosen by `srcb_sel` when `use_const` is 0.
- R3: When `wr_en` is 0, no register changes, whatever `dst_sel` and the write-back bus carry.
- R4: `use_const`=1 makes `const_in` the B operand (`b_data`). `use_const`=0 makes the B-port register the B operand.
- R5: `load_from_mem`=0 puts the function result on `wb_data`. `load_from_mem`=1 puts the memory word at the current address on `wb_data`.
- R6: The memory address is the low RAM_AW bits (6 by default) of `a_data`, so addresses 0x0005 and 0x0045 name the same word. The memory stores `b_data` at the rising edge only when `mem_wr` is 1. A read needs no clock.
- R7: Operation code 5'b10000 passes the B operand to `fn_result` unchanged.
- R8: The arithmetic codes are 5'b00010 (A+B), 5'b00101 (A-B, formed as A + not B + 1) and 5'b00001 (A+1), all modulo 2^16.
- R9: The other codes are 5'b00000 (pass A), 5'b01000 (A AND B), 5'b01010 (A OR B), 5'b01100 (A XOR B), 5'b01110 (NOT A), 5'b11000 (B shifted left by one with a 0 filled in) and 5'b10100 (B shifted right by one with a 0 filled in).
- R10: For every code, `flag_n` equals result bit 15 and `flag_z` is 1 exactly when the result is zero.
- R11: For the three arithmetic codes, `flag_c` is the carry out of bit 15 and `flag_v` is two's-complement overflow. For a subtract, C=1 means there was no borrow. For every other code, C and V are 0.
- R12: Any code not listed in R7 to R9 gives a zero result, so Z=1 and N, C and V are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the register file |
| wr_en | input | 1 | Register write enable |
| dst_sel | input | 3 | Destination register select |
| srca_sel | input | 3 | Read port A select |
| srcb_sel | input | 3 | Read port B select |
| use_const | input | 1 | Choose `const_in` as operand B |
| func_sel | input | 5 | Function unit operation code |
| load_from_mem | input | 1 | Choose memory word for write-back |
| mem_wr | input | 1 | Data memory write enable |
| const_in | input | 16 | External constant operand |
| a_data | output | 16 | Read port A value (also memory address) |
| b_data | output | 16 | Selected B operand (also memory write data) |
| fn_result | output | 16 | Function unit result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| wb_data | output | 16 | Write-back bus |

## Verification
A wrong value in a register, whether from a missed write, a write to the wrong slot or a stray write, appears on `a_data` in the same cycle that register is selected, so every update is read back right after the edge that made it. A wrong memory word stays hidden until a load selects its address. The word then shows on `wb_data` in that cycle and in the destination register one edge later, so each store is followed by a load from the same address and from an aliased one. Flag faults show without any clock at all, so the operand corners (signed overflow, carry out, zero result, borrow) are applied and the flags read before any edge.

// File: rtl/dp_pkg.sv
package dp_pkg;

  localparam int FS_W = 5;

  typedef enum logic [FS_W-1:0] {
    OP_PASSA = 5'b00000,
    OP_INC   = 5'b00001,
    OP_ADD   = 5'b00010,
    OP_SUB   = 5'b00101,
    OP_AND   = 5'b01000,
    OP_OR    = 5'b01010,
    OP_XOR   = 5'b01100,
    OP_NOT   = 5'b01110,
    OP_PASSB = 5'b10000,
    OP_SHR   = 5'b10100,
    OP_SHL   = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W    = 16,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [W-1:0]    wdata,
  input  logic [SELW-1:0] rsel_a,
  input  logic [SELW-1:0] rsel_b,
  output logic [W-1:0]    rdata_a,
  output logic [W-1:0]    rdata_b
);

  localparam int NREG = 1 << SELW;

  logic [W-1:0] slot [NREG];

  // one independently enabled register per select value
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic [W-1:0] q;
    logic         hit;
    assign hit = we && (wsel == SELW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (hit) begin
        q <= wdata;
      end
    end
    assign slot[i] = q;
  end

  assign rdata_a = slot[rsel_a];
  assign rdata_b = slot[rsel_b];

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [FS_W-1:0] fs,
  output logic [W-1:0]    res,
  output flags_t          flg
);

  localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

  logic [W:0]   sum;
  logic [W-1:0] r;
  logic         cy;
  logic         ov;

  always_comb begin
    sum = '0;
    r   = '0;
    cy  = 1'b0;
    ov  = 1'b0;
    case (fs)
      OP_ADD: begin
        sum = {1'b0, opa} + {1'b0, opb};
        r   = sum[W-1:0];
        cy  = sum[W];
        ov  = (opa[W-1] == opb[W-1]) && (r[W-1] != opa[W-1]);
      end
      OP_SUB: begin
        sum = {1'b0, opa} + {1'b0, ~opb} + ONE_X;
        r   = sum[W-1:0];
        cy  = sum[W];
        ov  = (opa[W-1] != opb[W-1]) && (r[W-1] != opa[W-1]);
      end
      OP_INC: begin
        sum = {1'b0, opa} + ONE_X;
        r   = sum[W-1:0];
        cy  = sum[W];
        ov  = !opa[W-1] && r[W-1];
      end
      OP_PASSA: r = opa;
      OP_PASSB: r = opb;
      OP_AND:   r = opa & opb;
      OP_OR:    r = opa | opb;
      OP_XOR:   r = opa ^ opb;
      OP_NOT:   r = ~opa;
      OP_SHL:   r = {opb[W-2:0], 1'b0};
      OP_SHR:   r = {1'b0, opb[W-1:1]};
      default:  r = '0;
    endcase
  end

  assign res   = r;
  assign flg.v = ov;
  assign flg.c = cy;
  assign flg.n = r[W-1];
  assign flg.z = (r == '0);

endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/regrtx_datapath.sv
module regrtx_datapath
  import dp_pkg::*;
#(
  parameter int W      = 16,
  parameter int SELW   = 3,
  parameter int RAM_AW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] dst_sel,
  input  logic [SELW-1:0] srca_sel,
  input  logic [SELW-1:0] srcb_sel,
  input  logic            use_const,
  input  logic [FS_W-1:0] func_sel,
  input  logic            load_from_mem,
  input  logic            mem_wr,
  input  logic [W-1:0]    const_in,
  output logic [W-1:0]    a_data,
  output logic [W-1:0]    b_data,
  output logic [W-1:0]    fn_result,
  output logic            flag_v,
  output logic            flag_c,
  output logic            flag_n,
  output logic            flag_z,
  output logic [W-1:0]    wb_data
);

  logic [W-1:0]      rf_b;
  logic [W-1:0]      ram_q;
  logic [RAM_AW-1:0] ram_addr;
  flags_t            alu_flg;

  dp_regfile #(.W(W), .SELW(SELW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .wsel    (dst_sel),
    .wdata   (wb_data),
    .rsel_a  (srca_sel),
    .rsel_b  (srcb_sel),
    .rdata_a (a_data),
    .rdata_b (rf_b)
  );

  // operand B: register port or external constant
  assign b_data = use_const ? const_in : rf_b;

  dp_alu #(.W(W)) u_alu (
    .opa (a_data),
    .opb (b_data),
    .fs  (func_sel),
    .res (fn_result),
    .flg (alu_flg)
  );

  assign ram_addr = a_data[RAM_AW-1:0];

  dp_ram #(.W(W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (mem_wr),
    .addr  (ram_addr),
    .wdata (b_data),
    .rdata (ram_q)
  );

  assign wb_data = load_from_mem ? ram_q : fn_result;

  assign flag_v = alu_flg.v;
  assign flag_c = alu_flg.c;
  assign flag_n = alu_flg.n;
  assign flag_z = alu_flg.z;

endmodule

// File: rtl/dp_checker.sv
module dp_checker
  import dp_pkg::*;
#(
  parameter int W      = 16,
  parameter int SELW   = 3,
  parameter int RAM_AW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [SELW-1:0] dst_sel,
  input logic [SELW-1:0] srca_sel,
  input logic            use_const,
  input logic [FS_W-1:0] func_sel,
  input logic            load_from_mem,
  input logic            mem_wr,
  input logic [W-1:0]    const_in,
  input logic [W-1:0]    a_data,
  input logic [W-1:0]    b_data,
  input logic [W-1:0]    fn_result,
  input logic            flag_v,
  input logic            flag_c,
  input logic            flag_n,
  input logic            flag_z,
  input logic [W-1:0]    wb_data
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_data == '0));

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && (srca_sel == $past(dst_sel)))
      |-> (a_data == $past(wb_data)));

  assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && (srca_sel == $past(srca_sel)))
      |-> (a_data == $past(a_data)));

  // R7 as well: pass-B of a constant reaches the result
  assert_passb_const_R4: assert property (@(posedge clk) disable iff (rst)
    (use_const && (func_sel == OP_PASSB)) |-> (fn_result == const_in));

  // R5 as well: a load right after a store returns the stored operand
  assert_store_load_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mem_wr) && load_from_mem &&
     (a_data[RAM_AW-1:0] == $past(a_data[RAM_AW-1:0])))
      |-> (wb_data == $past(b_data)));

  assert_nz_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(flag_n && flag_z));

  assert_cv_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !(func_sel inside {OP_INC, OP_ADD, OP_SUB}) |-> (!flag_c && !flag_v));

endmodule

bind regrtx_datapath dp_checker #(.W(W), .SELW(SELW), .RAM_AW(RAM_AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .dst_sel       (dst_sel),
  .srca_sel      (srca_sel),
  .use_const     (use_const),
  .func_sel      (func_sel),
  .load_from_mem (load_from_mem),
  .mem_wr        (mem_wr),
  .const_in      (const_in),
  .a_data        (a_data),
  .b_data        (b_data),
  .fn_result     (fn_result),
  .flag_v        (flag_v),
  .flag_c        (flag_c),
  .flag_n        (flag_n),
  .flag_z        (flag_z),
  .wb_data       (wb_data)
);

// File: tb/regrtx_datapath_tb.sv
`timescale 1ns/1ps
module regrtx_datapath_tb_top;
  import dp_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, use_const = 1'b0, load_from_mem = 1'b0, mem_wr = 1'b0;
  logic [2:0]  dst_sel = '0, srca_sel = '0, srcb_sel = '0;
  logic [4:0]  func_sel = '0;
  logic [15:0] const_in = '0;
  logic [15:0] a_data, b_data, fn_result, wb_data;
  logic        flag_v, flag_c, flag_n, flag_z;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  regrtx_datapath dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .dst_sel(dst_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .use_const(use_const), .func_sel(func_sel),
    .load_from_mem(load_from_mem), .mem_wr(mem_wr), .const_in(const_in),
    .a_data(a_data), .b_data(b_data), .fn_result(fn_result), .flag_v(flag_v),
    .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .wb_data(wb_data)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [2:0] d, a, b, input logic mb,
                       input logic [4:0] fs, input logic md, mw, input logic [15:0] k);
    wr_en = wr; dst_sel = d; srca_sel = a; srcb_sel = b; use_const = mb;
    func_sel = fs; load_from_mem = md; mem_wr = mw; const_in = k;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_k(input logic [2:0] r, input logic [15:0] k);
    drive(1'b1, r, 3'd0, 3'd0, 1'b1, OP_PASSB, 1'b0, 1'b0, k);
    step();
  endtask

  task automatic peek(input logic [2:0] r, output logic [15:0] v);
    drive(1'b0, 3'd0, r, r, 1'b0, OP_PASSA, 1'b0, 1'b0, 16'h0);
    #2 v = a_data;
  endtask

  task automatic alu_case(input string req, input logic [15:0] av, input logic [4:0] fs,
                          input logic [15:0] bv, input logic [15:0] exp_r,
                          input logic [3:0] exp_vcnz);
    load_k(3'd1, av);
    drive(1'b0, 3'd0, 3'd1, 3'd0, 1'b1, fs, 1'b0, 1'b0, bv);
    #2;
    check(req, "result", fn_result, exp_r);
    check(req, "flags vcnz", {12'h0, flag_v, flag_c, flag_n, flag_z}, {12'h0, exp_vcnz});
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      peek(3'(i), v);
      check("R1", "reg after reset", v, 16'h0000);
    end
  endtask

  task automatic t_write_read();
    logic [15:0] v;
    for (int i = 1; i < 8; i++) load_k(3'(i), 16'h1100 + 16'(i));
    for (int i = 1; i < 8; i++) begin
      drive(1'b0, 3'd0, 3'(i), 3'(8 - i), 1'b0, OP_PASSA, 1'b0, 1'b0, 16'hFFFF);
      #2;
      check("R2", "port A", a_data, 16'h1100 + 16'(i));
      check("R4", "port B register", b_data, 16'h1100 + 16'(8 - i));
    end
    // R5: register operands through add written back with load_from_mem=0
    drive(1'b1, 3'd6, 3'd2, 3'd3, 1'b0, OP_ADD, 1'b0, 1'b0, 16'h0);
    step();
    peek(3'd6, v);
    check("R5", "add written back", v, 16'h2205);
  endtask

  task automatic t_no_write();
    logic [15:0] v;
    drive(1'b0, 3'd3, 3'd0, 3'd0, 1'b1, OP_PASSB, 1'b0, 1'b0, 16'hDEAD);
    step();
    peek(3'd3, v);
    check("R3", "reg with wr_en low", v, 16'h1103);
  endtask

  task automatic t_arith();
    alu_case("R8", 16'h7FFF, OP_ADD, 16'h0001, 16'h8000, 4'b1010);
    alu_case("R11", 16'hFFFF, OP_ADD, 16'h0001, 16'h0000, 4'b0101);
    alu_case("R11", 16'h0005, OP_SUB, 16'h0005, 16'h0000, 4'b0101);
    alu_case("R8", 16'h0003, OP_SUB, 16'h0005, 16'hFFFE, 4'b0010);
    alu_case("R11", 16'h8000, OP_SUB, 16'h0001, 16'h7FFF, 4'b1100);
    alu_case("R8", 16'h7FFF, OP_INC, 16'h0000, 16'h8000, 4'b1010);
    alu_case("R11", 16'hFFFF, OP_INC, 16'h0000, 16'h0000, 4'b0101);
  endtask

  task automatic t_logic();
    alu_case("R9", 16'hF0F0, OP_AND, 16'h0FF0, 16'h00F0, 4'b0000);
    alu_case("R9", 16'hF0F0, OP_OR, 16'h0FF0, 16'hFFF0, 4'b0010);
    alu_case("R10", 16'hAAAA, OP_XOR, 16'hAAAA, 16'h0000, 4'b0001);
    alu_case("R9", 16'h00FF, OP_NOT, 16'h1234, 16'hFF00, 4'b0010);
    alu_case("R9", 16'h1234, OP_PASSA, 16'h5678, 16'h1234, 4'b0000);
    alu_case("R7", 16'h1234, OP_PASSB, 16'h8765, 16'h8765, 4'b0010);
    alu_case("R11", 16'h0000, OP_SHL, 16'h8001, 16'h0002, 4'b0000);
    alu_case("R11", 16'h0000, OP_SHR, 16'h8001, 16'h4000, 4'b0000);
    alu_case("R12", 16'h7777, 5'b00011, 16'h1111, 16'h0000, 4'b0001);
    alu_case("R12", 16'h7777, 5'b11111, 16'h1111, 16'h0000, 4'b0001);
  endtask

  task automatic t_memory();
    logic [15:0] v;
    load_k(3'd1, 16'h0005);
    load_k(3'd2, 16'h0006);
    load_k(3'd5, 16'hC0DE);
    load_k(3'd7, 16'h0045);
    // constant stored straight to memory
    drive(1'b0, 3'd0, 3'd1, 3'd0, 1'b1, OP_PASSA, 1'b0, 1'b1, 16'hBEEF);
    step();
    // register value stored
    drive(1'b0, 3'd0, 3'd2, 3'd5, 1'b0, OP_PASSA, 1'b0, 1'b1, 16'h0000);
    step();
    drive(1'b1, 3'd4, 3'd1, 3'd0, 1'b0, OP_PASSA, 1'b1, 1'b0, 16'h0000);
    #2 check("R5", "wb bus carries memory", wb_data, 16'hBEEF);
    step();
    peek(3'd4, v);
    check("R6", "constant store then load", v, 16'hBEEF);
    drive(1'b0, 3'd0, 3'd2, 3'd0, 1'b0, OP_PASSA, 1'b1, 1'b0, 16'h0000);
    #2 check("R6", "register store then load", wb_data, 16'hC0DE);
    // mem_wr low must not change word 5
    drive(1'b0, 3'd0, 3'd1, 3'd0, 1'b1, OP_PASSB, 1'b0, 1'b0, 16'h1111);
    #2 check("R5", "wb bus carries result", wb_data, 16'h1111);
    step();
    drive(1'b0, 3'd0, 3'd1, 3'd0, 1'b0, OP_PASSA, 1'b1, 1'b0, 16'h0000);
    #2 check("R6", "word kept with mem_wr low", wb_data, 16'hBEEF);
    // 0x0045 aliases to word 5
    drive(1'b0, 3'd0, 3'd7, 3'd0, 1'b0, OP_PASSA, 1'b1, 1'b0, 16'h0000);
    #2 check("R6", "address low bits only", wb_data, 16'hBEEF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_no_write();
    t_arith();
    t_logic();
    t_memory();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule